// File: doc/BRIEF.md
# Circular and Bit-Reversed Address Generator

This block is an integer address unit for a signal-processing datapath. It holds four working registers: an index, a signed step (the modify amount), a buffer base and a buffer span (the length). A fifth register holds the width of the bit-reversal field. Software-side logic writes them through a single load port with a select code. The datapath raises an access strobe together with a mode bit. In the same cycle the block presents an address. At the closing clock edge it post-modifies the index.

In circular mode the address is the index itself. The updated index folds back into the window from base to base+span-1 whenever the step carries it past either end, so a delay line or sample history can be walked forever without moving data. In bit-reverse mode the low N bits of the address are the mirrored low N bits of the index, and the upper bits come from the base. This gives the scrambled ordering that radix-2 FFT passes need. In that mode the index simply advances by the step.

Top module: `circ_brev_agen`

## Requirements
- R1: While `acc_en` is high, `addr_out` shows the address for the current index in that same cycle, and the index takes its post-modified value at the clock edge that ends the cycle. In circular mode (`acc_mode`=0) the address equals the index.
- R2: In circular mode with a non-zero span, if index+step is at or above base+span, the new index is index+step-span.
- R3: In circular mode with a negative step (two's complement) and a non-zero span, if index+step falls below base, the new index is index+step+span.
- R4: In circular mode, when neither bound is crossed the new index is index+step. Starting inside the window with |step| < span, the index stays inside the window, including at step = ±(span-1).
- R5: In circular mode with span 0 no wrap is applied, and the index advances by the step modulo 2^16.
- R6: In bit-reverse mode (`acc_mode`=1), address bit i equals index bit N-1-i for i < N, and address bits N and above equal the same bits of the base. N is the stored width field plus one, so it ranges from 1 to 16, and N=16 uses no base bits.
- R7: In bit-reverse mode the new index is index+step modulo 2^16, with no window check.
- R8: The load select codes are: 0 = index, 1 = step, 2 = base, 3 = span, 4 = reversal width (`ld_val[3:0]` holds N-1). Codes 5 to 7 change nothing. A load takes effect from the next cycle. When an index load and an access fall in the same cycle, the access uses the old index and the loaded value replaces the post-modified one.
- R9: Reset clears every register. After reset a circular access gives address 0, and a bit-reverse access gives address 0 with N=1.
- R10: In a cycle with neither an access nor a load, the index is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Register load strobe |
| ld_sel | input | 3 | Register select for the load (codes per R8) |
| ld_val | input | AW | Value to load |
| acc_en | input | 1 | Access strobe |
| acc_mode | input | 1 | 0 = circular, 1 = bit-reverse |
| addr_out | output | AW | Address for the current access |

## Verification
The bench builds the block with its default 16-bit address width, so the reversal width field covers N from 1 to the full 16. This brings within reach the case where no base bit survives as well as the single-bit case left after reset. The full 16-bit width also lets the bench run the index across the 0xFFFF/0x0000 boundary in both the linear and the span-zero paths. It gives room for windows away from zero, so that wraps in both directions and steps of exactly ±(span-1) are exercised with a base that is not zero.

// File: rtl/agen_pkg.sv
package agen_pkg;

    // load port register select codes
    typedef enum logic [2:0] {
        SEL_INDEX = 3'd0,
        SEL_STEP  = 3'd1,
        SEL_BASE  = 3'd2,
        SEL_SPAN  = 3'd3,
        SEL_REVW  = 3'd4
    } ld_sel_e;

    // access mode
    typedef enum logic {
        MODE_CIRC = 1'b0,
        MODE_BREV = 1'b1
    } acc_mode_e;

endpackage

// File: rtl/agen_regs.sv
module agen_regs
    import agen_pkg::*;
#(
    parameter int unsigned AW = 16,
    parameter int unsigned RW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_en,
    input  logic [2:0]    ld_sel,
    input  logic [AW-1:0] ld_val,
    input  logic          acc_en,
    input  logic [AW-1:0] idx_upd,
    output logic [AW-1:0] idx_q,
    output logic [AW-1:0] step_q,
    output logic [AW-1:0] base_q,
    output logic [AW-1:0] span_q,
    output logic [RW-1:0] revw_q
);

    typedef struct packed {
        logic [AW-1:0] idx;
        logic [AW-1:0] step;
        logic [AW-1:0] base;
        logic [AW-1:0] span;
        logic [RW-1:0] revw;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // post-modify first, so an index load in the same cycle wins
        if (acc_en) begin
            st_d.idx = idx_upd;
        end
        if (ld_en) begin
            case (ld_sel)
                SEL_INDEX: st_d.idx  = ld_val;
                SEL_STEP:  st_d.step = ld_val;
                SEL_BASE:  st_d.base = ld_val;
                SEL_SPAN:  st_d.span = ld_val;
                SEL_REVW:  st_d.revw = ld_val[RW-1:0];
                default:   st_d      = st_d;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign idx_q  = st_q.idx;
    assign step_q = st_q.step;
    assign base_q = st_q.base;
    assign span_q = st_q.span;
    assign revw_q = st_q.revw;

endmodule

// File: rtl/agen_circ.sv
module agen_circ #(
    parameter int unsigned AW = 16
) (
    input  logic [AW-1:0] idx,
    input  logic [AW-1:0] step,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] span,
    output logic [AW-1:0] idx_wrap
);

    // two guard bits: one for the carry above base+span, one for sign
    localparam int unsigned EW = AW + 2;

    logic signed [EW-1:0] sum_s;
    logic signed [EW-1:0] lo_s;
    logic signed [EW-1:0] hi_s;
    logic signed [EW-1:0] span_s;
    logic signed [EW-1:0] res_s;
    logic                 step_neg;

    always_comb begin
        step_neg = step[AW-1];
        span_s   = $signed({2'b00, span});
        sum_s    = $signed({2'b00, idx}) + $signed({{2{step[AW-1]}}, step});
        lo_s     = $signed({2'b00, base});
        hi_s     = lo_s + span_s;
        res_s    = sum_s;
        if (span != '0) begin
            if (!step_neg && (sum_s >= hi_s)) begin
                res_s = sum_s - span_s;
            end else if (step_neg && (sum_s < lo_s)) begin
                res_s = sum_s + span_s;
            end
        end
        idx_wrap = res_s[AW-1:0];
    end

endmodule

// File: rtl/agen_brev.sv
module agen_brev #(
    parameter int unsigned AW = 16,
    parameter int unsigned RW = 4
) (
    input  logic [AW-1:0] idx,
    input  logic [AW-1:0] base,
    input  logic [RW-1:0] revw,
    output logic [AW-1:0] addr
);

    localparam logic [RW:0] TOP = RW'(AW - 1);

    logic [AW-1:0] rev_full;
    logic [RW:0]   shamt;
    logic [AW-1:0] rev_low;
    logic [AW-1:0] low_mask;

    // mirror the whole index once; the field width then picks a right shift
    for (genvar g = 0; g < AW; g++) begin : g_mirror
        assign rev_full[g] = idx[AW-1-g];
    end

    always_comb begin
        shamt    = TOP - {1'b0, revw};
        rev_low  = rev_full >> shamt;
        low_mask = {AW{1'b1}} >> shamt;
        addr     = (base & ~low_mask) | (rev_low & low_mask);
    end

endmodule

// File: rtl/circ_brev_agen.sv
module circ_brev_agen
    import agen_pkg::*;
#(
    parameter int unsigned AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_en,
    input  logic [2:0]    ld_sel,
    input  logic [AW-1:0] ld_val,
    input  logic          acc_en,
    input  logic          acc_mode,
    output logic [AW-1:0] addr_out
);

    localparam int unsigned RW = $clog2(AW);

    logic [AW-1:0] idx_q;
    logic [AW-1:0] step_q;
    logic [AW-1:0] base_q;
    logic [AW-1:0] span_q;
    logic [RW-1:0] revw_q;
    logic [AW-1:0] idx_circ;
    logic [AW-1:0] idx_lin;
    logic [AW-1:0] idx_upd;
    logic [AW-1:0] addr_rev;

    agen_regs #(.AW(AW), .RW(RW)) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_en   (ld_en),
        .ld_sel  (ld_sel),
        .ld_val  (ld_val),
        .acc_en  (acc_en),
        .idx_upd (idx_upd),
        .idx_q   (idx_q),
        .step_q  (step_q),
        .base_q  (base_q),
        .span_q  (span_q),
        .revw_q  (revw_q)
    );

    agen_circ #(.AW(AW)) i_circ (
        .idx      (idx_q),
        .step     (step_q),
        .base     (base_q),
        .span     (span_q),
        .idx_wrap (idx_circ)
    );

    agen_brev #(.AW(AW), .RW(RW)) i_brev (
        .idx  (idx_q),
        .base (base_q),
        .revw (revw_q),
        .addr (addr_rev)
    );

    always_comb begin
        idx_lin = idx_q + step_q;
        if (acc_mode == MODE_BREV) begin
            idx_upd  = idx_lin;
            addr_out = addr_rev;
        end else begin
            idx_upd  = idx_circ;
            addr_out = idx_q;
        end
    end

endmodule

// File: rtl/agen_chk.sv
module agen_chk #(
    parameter int unsigned AW = 16,
    parameter int unsigned RW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ld_en,
    input logic [2:0]    ld_sel,
    input logic [AW-1:0] ld_val,
    input logic          acc_en,
    input logic          acc_mode,
    input logic [AW-1:0] addr_out,
    input logic [AW-1:0] idx_q,
    input logic [AW-1:0] step_q,
    input logic [AW-1:0] base_q,
    input logic [AW-1:0] span_q,
    input logic [RW-1:0] revw_q
);

    logic [AW-1:0] fmask;
    logic [AW:0]   win_end;
    logic          in_win;
    logic [AW-1:0] step_mag;
    logic          step_ok;

    always_comb begin
        for (int i = 0; i < AW; i++) begin
            fmask[i] = (i <= int'(revw_q));
        end
        win_end  = {1'b0, base_q} + {1'b0, span_q};
        in_win   = ({1'b0, idx_q} >= {1'b0, base_q}) && ({1'b0, idx_q} < win_end);
        step_mag = step_q[AW-1] ? (~step_q + 1'b1) : step_q;
        step_ok  = step_mag < span_q;
    end

    // R1: circular address is the index held in this cycle
    assert_circ_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_mode) |-> (addr_out == idx_q));

    // R4: a legal step never leaves the window
    assert_stay_in_win_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_mode && !ld_en && (span_q != '0) && in_win && step_ok) |=> in_win);

    // R6: upper address bits come from the base
    assert_brev_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_mode) |-> ((addr_out & ~fmask) == (base_q & ~fmask)));

    // R6: mirroring keeps the number of set bits in the field
    assert_brev_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_mode) |-> ($countones(addr_out & fmask) == $countones(idx_q & fmask)));

    // R7: bit-reverse post-modify is a plain add
    assert_brev_linear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_mode && !ld_en) |=> (idx_q == AW'($past(idx_q) + $past(step_q))));

    // R8: an index load lands on the next cycle
    assert_idx_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && (ld_sel == 3'd0)) |=> (idx_q == $past(ld_val)));

    // R10: idle cycles hold the index
    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_en && !ld_en) |=> $stable(idx_q));

endmodule

bind circ_brev_agen agen_chk #(.AW(AW), .RW(RW)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_en    (ld_en),
    .ld_sel   (ld_sel),
    .ld_val   (ld_val),
    .acc_en   (acc_en),
    .acc_mode (acc_mode),
    .addr_out (addr_out),
    .idx_q    (idx_q),
    .step_q   (step_q),
    .base_q   (base_q),
    .span_q   (span_q),
    .revw_q   (revw_q)
);

// File: tb/test_circ_brev_agen.sv
module test_circ_brev_agen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [2:0]  ld_sel = 3'd0;
    logic [15:0] ld_val = 16'd0;
    logic        acc_en = 1'b0;
    logic        acc_mode = 1'b0;
    logic [15:0] addr_out;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    circ_brev_agen #(.AW(16)) i_circ_brev_agen (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_en    (ld_en),
        .ld_sel   (ld_sel),
        .ld_val   (ld_val),
        .acc_en   (acc_en),
        .acc_mode (acc_mode),
        .addr_out (addr_out)
    );

    typedef struct {
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t sbq[$];

    // reference state, built from the requirements
    logic [15:0] m_idx = '0, m_step = '0, m_base = '0, m_span = '0;
    logic [3:0]  m_wm1 = '0;

    function automatic logic [15:0] rev_addr(input logic [15:0] idx, input logic [15:0] base,
                                             input int n);
        logic [15:0] r;
        r = base;
        for (int i = 0; i < n; i++) r[i] = idx[n-1-i];
        return r;
    endfunction

    function automatic logic [15:0] next_idx(input logic mode);
        int s, st, lo, hi;
        st = int'($signed(m_step));
        s  = int'(m_idx) + st;
        lo = int'(m_base);
        hi = int'(m_base) + int'(m_span);
        if (!mode && m_span != 16'd0) begin
            if (st >= 0 && s >= hi) s = s - int'(m_span);
            else if (st < 0 && s < lo) s = s + int'(m_span);
        end
        return s[15:0];
    endfunction

    function automatic void model_load(input logic [2:0] sel, input logic [15:0] v);
        case (sel)
            3'd0: m_idx  = v;
            3'd1: m_step = v;
            3'd2: m_base = v;
            3'd3: m_span = v;
            3'd4: m_wm1  = v[3:0];
            default: ;
        endcase
    endfunction

    // driver: one cycle of stimulus, pushing the expected address on accesses
    task automatic cyc(input logic do_acc, input logic mode, input logic do_ld,
                       input logic [2:0] sel, input logic [15:0] v, input string tag);
        item_t it;
        @(posedge clk);
        #1;
        acc_en   = do_acc;
        acc_mode = mode;
        ld_en    = do_ld;
        ld_sel   = sel;
        ld_val   = v;
        if (do_acc) begin
            it.exp = mode ? rev_addr(m_idx, m_base, int'(m_wm1) + 1) : m_idx;
            it.tag = tag;
            sbq.push_back(it);
            m_idx = next_idx(mode);
        end
        if (do_ld) model_load(sel, v);
    endtask

    task automatic ld(input logic [2:0] sel, input logic [15:0] v);
        cyc(1'b0, 1'b0, 1'b1, sel, v, "");
    endtask

    task automatic acc(input logic mode, input string tag);
        cyc(1'b1, mode, 1'b0, 3'd0, 16'd0, tag);
    endtask

    task automatic idle();
        cyc(1'b0, 1'b0, 1'b0, 3'd0, 16'd0, "");
    endtask

    // monitor: compare mid-cycle, away from the rising edge
    always @(negedge clk) begin
        if (rst_n && acc_en) begin
            item_t it;
            checks++;
            if (sbq.size() == 0) begin
                fails++;
                $display("FAIL R1: access with no expected item, actual %h expected none", addr_out);
            end else begin
                it = sbq.pop_front();
                if (addr_out !== it.exp) begin
                    fails++;
                    $display("FAIL %s: actual %h expected %h", it.tag, addr_out, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R9: cleared state
        acc(1'b0, "R9");
        acc(1'b1, "R9");

        // R2 / R1: upward wrap in a window away from zero
        ld(3'd2, 16'h0100); ld(3'd3, 16'd10); ld(3'd1, 16'd3); ld(3'd0, 16'h0100);
        for (int i = 0; i < 8; i++) acc(1'b0, (i < 3) ? "R1" : "R2");

        // R3: negative step, downward wrap
        ld(3'd1, 16'hFFFC);
        for (int i = 0; i < 8; i++) acc(1'b0, "R3");

        // R4: step of exactly +/-(span-1)
        ld(3'd0, 16'h0100); ld(3'd1, 16'd9);
        for (int i = 0; i < 5; i++) acc(1'b0, "R4");
        ld(3'd1, 16'hFFF7);
        for (int i = 0; i < 5; i++) acc(1'b0, "R4");

        // R5: span zero, no wrap, crosses 0xFFFF
        ld(3'd3, 16'd0); ld(3'd1, 16'd3); ld(3'd0, 16'hFFFE);
        for (int i = 0; i < 3; i++) acc(1'b0, "R5");

        // R6 / R7: 8-bit reversal with base high bits
        ld(3'd2, 16'hAB00); ld(3'd4, 16'd7); ld(3'd1, 16'd1); ld(3'd0, 16'd0);
        for (int i = 0; i < 8; i++) acc(1'b1, "R6");
        // full 16-bit field, no base bits
        ld(3'd4, 16'd15); ld(3'd0, 16'h0001); ld(3'd1, 16'h0102);
        for (int i = 0; i < 3; i++) acc(1'b1, "R6");
        // 3-bit field
        ld(3'd2, 16'h1234); ld(3'd4, 16'd2); ld(3'd0, 16'd6); ld(3'd1, 16'd1);
        for (int i = 0; i < 3; i++) acc(1'b1, "R6");
        // R7: linear carry through 0xFFFF in bit-reverse mode, window ignored
        ld(3'd3, 16'd4); ld(3'd4, 16'd15); ld(3'd0, 16'hFFFF); ld(3'd1, 16'd2);
        for (int i = 0; i < 3; i++) acc(1'b1, "R7");

        // R8: load and access in one cycle, then ignored codes
        ld(3'd2, 16'h0200); ld(3'd3, 16'd16); ld(3'd1, 16'd5); ld(3'd0, 16'h0204);
        cyc(1'b1, 1'b0, 1'b1, 3'd0, 16'h020A, "R8");
        acc(1'b0, "R8");
        ld(3'd5, 16'h0000); ld(3'd6, 16'hFFFF); ld(3'd7, 16'h1234);
        acc(1'b0, "R8");
        acc(1'b0, "R8");

        // R10: idle cycles leave the index alone
        idle(); idle(); idle();
        acc(1'b0, "R10");

        idle(); idle();
        @(negedge clk);
        checks++;
        if (sbq.size() != 0) begin
            fails++;
            $display("FAIL R1: actual %0d items left expected 0", sbq.size());
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule